// File: doc/BRIEF.md
# Vector Indexed Register Move Unit

This unit performs a gather-style register move across a vector of elements. A single command supplies three register numbers and a vector length: an index base, a source base and a destination base. For each element position `i` from zero up to the length minus one, the unit reads an index value from register `index base + i`, confirms that the index is below the vector length, then copies register `source base + index` into register `destination base + i`. Indices are relative to the source base, so one command can repeat, permute or spread source elements freely.

The unit owns no storage of its own. It reaches the register file through one read port with a fixed one-cycle latency and one write port. Before any access, the command is checked so that no base plus the length can reach the end of the file. Elements are handled strictly in ascending order, one at a time. The unit stops on the first fault and reports which kind of fault it was and where it occurred. A completed run ends with a one-cycle done pulse.

Top module: `vidx_move`

## Requirements
- R1: After reset, `busy`, `done`, `trap`, `rf_rd_en` and `rf_wr_en` are all low.
- R2: For every element `i` below the length, register `dst_base+i` ends up holding the value register `src_base+idx` had when the element ran, where `idx` is the value read from register `idx_base+i`.
- R3: Repeated indices are legal. With indices 5,5,3,3,4,4,4, the seven destinations receive source elements 5,5,3,3,4,4,4.
- R4: When the length is nonzero and any of the three bases plus the length is greater than or equal to the register count, `trap` pulses with `trap_cause` = 1 and `trap_elem` = 0. No register-file read or write takes place.
- R5: When an index value is greater than or equal to the length, `trap` pulses with `trap_cause` = 2 and `trap_elem` = the faulting element. Earlier elements keep their writes. No later element is written.
- R6: Elements run in ascending order. Each element's write lands before the next element's index read, so a destination that overlaps a later index register affects that later element.
- R7: `done` is a one-cycle pulse that comes after the last element's write has landed. `done` and `trap` are never high together.
- R8: A command with length 0 gives a `done` pulse in the next cycle, with no register-file access.
- R9: A `start` that arrives while `busy` is high is ignored. It does not change the running move and does not queue another one.
- R10: Boundary values are legal. An index equal to the length minus one is accepted, and a base plus the length equal to the register count minus one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| idx_base | input | AW | First register of the index vector |
| src_base | input | AW | Register that index value 0 selects |
| dst_base | input | AW | First destination register |
| vlen | input | LW | Number of elements |
| rf_rd_en | output | 1 | Register-file read request |
| rf_rd_addr | output | AW | Read register number |
| rf_rd_data | input | DW | Read data, valid one cycle after the request |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_addr | output | AW | Write register number |
| rf_wr_data | output | DW | Write data |
| busy | output | 1 | A move is in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | One-cycle fault pulse |
| trap_cause | output | 2 | 1 = base range fault, 2 = index fault |
| trap_elem | output | LW | Element number of an index fault |

## Verification
The hardest case to bring about is the ordering hazard, where an element's write changes an index that a later element will read. From the ports this only shows up when the destination range overlaps the index range by one register. The bench sets up exactly that layout, seeds the index vector so that stale and fresh reads lead to different copies, and compares the result against a strictly sequential model. A start pulse sent in the middle of a run also checks that a second command is dropped rather than merged into the first.

// File: rtl/vidx_move_pkg.sv
package vidx_move_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_RANGE = 2'd1,
    CAUSE_INDEX = 2'd2
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IDX_WAIT,
    ST_IDX_CHK,
    ST_DAT_WAIT,
    ST_DAT_PUT,
    ST_NEXT,
    ST_FIN
  } step_e;

endpackage

// File: rtl/vidx_range_check.sv
module vidx_range_check #(
  parameter int NREG   = 32,
  parameter int AW     = 5,
  parameter int LW     = 6,
  parameter int NBASES = 3
) (
  input  logic [NBASES*AW-1:0] bases,
  input  logic [LW-1:0]        len,
  output logic                 bad
);
  localparam int SW = LW + 1;
  localparam logic [SW-1:0] LIMIT = SW'(NREG);

  logic [NBASES-1:0] over;

  for (genvar k = 0; k < NBASES; k++) begin : g_base
    logic [SW-1:0] reach;
    assign reach   = SW'(bases[k*AW +: AW]) + SW'(len);
    assign over[k] = (reach >= LIMIT);
  end

  assign bad = |over;
endmodule

// File: rtl/vidx_seq.sv
module vidx_seq
  import vidx_move_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = 5,
  parameter int LW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] idx_base,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [LW-1:0] vlen,
  input  logic          range_bad,
  output logic          rf_rd_en,
  output logic [AW-1:0] rf_rd_addr,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_wr_en,
  output logic [AW-1:0] rf_wr_addr,
  output logic [DW-1:0] rf_wr_data,
  output logic          busy,
  output logic          done,
  output logic          trap,
  output logic [1:0]    trap_cause,
  output logic [LW-1:0] trap_elem
);
  step_e         step;
  logic [AW-1:0] ra_q, rb_q, rd_q;
  logic [LW-1:0] vl_q;
  logic [LW-1:0] elem;

  logic          idx_over;
  logic          last_elem;
  logic [AW-1:0] idx_trim;

  assign idx_over  = (rf_rd_data >= DW'(vl_q));
  assign last_elem = (elem == vl_q - LW'(1));
  assign idx_trim  = rf_rd_data[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= ST_IDLE;
      ra_q       <= '0;
      rb_q       <= '0;
      rd_q       <= '0;
      vl_q       <= '0;
      elem       <= '0;
      rf_rd_en   <= 1'b0;
      rf_rd_addr <= '0;
      rf_wr_en   <= 1'b0;
      rf_wr_addr <= '0;
      rf_wr_data <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      trap       <= 1'b0;
      trap_cause <= CAUSE_NONE;
      trap_elem  <= '0;
    end else begin
      done     <= 1'b0;
      trap     <= 1'b0;
      rf_rd_en <= 1'b0;
      rf_wr_en <= 1'b0;
      unique case (step)
        ST_IDLE: begin
          if (start) begin
            if (vlen == '0) begin
              done       <= 1'b1;
              trap_cause <= CAUSE_NONE;
            end else if (range_bad) begin
              trap       <= 1'b1;
              trap_cause <= CAUSE_RANGE;
              trap_elem  <= '0;
            end else begin
              ra_q       <= idx_base;
              rb_q       <= src_base;
              rd_q       <= dst_base;
              vl_q       <= vlen;
              elem       <= '0;
              busy       <= 1'b1;
              trap_cause <= CAUSE_NONE;
              rf_rd_en   <= 1'b1;
              rf_rd_addr <= idx_base;
              step       <= ST_IDX_WAIT;
            end
          end
        end
        ST_IDX_WAIT: step <= ST_IDX_CHK;
        ST_IDX_CHK: begin
          if (idx_over) begin
            trap       <= 1'b1;
            trap_cause <= CAUSE_INDEX;
            trap_elem  <= elem;
            busy       <= 1'b0;
            step       <= ST_IDLE;
          end else begin
            rf_rd_en   <= 1'b1;
            rf_rd_addr <= rb_q + idx_trim;
            step       <= ST_DAT_WAIT;
          end
        end
        ST_DAT_WAIT: step <= ST_DAT_PUT;
        ST_DAT_PUT: begin
          rf_wr_en   <= 1'b1;
          rf_wr_addr <= rd_q + AW'(elem);
          rf_wr_data <= rf_rd_data;
          if (last_elem) begin
            step <= ST_FIN;
          end else begin
            elem <= elem + LW'(1);
            step <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          rf_rd_en   <= 1'b1;
          rf_rd_addr <= ra_q + AW'(elem);
          step       <= ST_IDX_WAIT;
        end
        ST_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          step <= ST_IDLE;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

  // R5: once a fault is flagged, no write follows
  assert_no_write_after_trap_R5: assert property (@(posedge clk) disable iff (rst)
    trap |=> !rf_wr_en);

  // R7: completion is a single-cycle strobe, never together with a fault
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_trap_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && trap));

  // R6: an element's write never shares a cycle with a read
  assert_write_alone_R6: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> !rf_rd_en);

  // R9: a command arriving mid-run leaves the latched command untouched
  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(vl_q) && $stable(rd_q) && $stable(rb_q)));
endmodule

// File: rtl/vidx_move.sv
module vidx_move #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG),
  parameter int LW   = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] idx_base,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [LW-1:0] vlen,
  output logic          rf_rd_en,
  output logic [AW-1:0] rf_rd_addr,
  input  logic [DW-1:0] rf_rd_data,
  output logic          rf_wr_en,
  output logic [AW-1:0] rf_wr_addr,
  output logic [DW-1:0] rf_wr_data,
  output logic          busy,
  output logic          done,
  output logic          trap,
  output logic [1:0]    trap_cause,
  output logic [LW-1:0] trap_elem
);
  localparam int NBASES = 3;

  logic range_bad;

  vidx_range_check #(
    .NREG(NREG), .AW(AW), .LW(LW), .NBASES(NBASES)
  ) u_range (
    .bases ({dst_base, src_base, idx_base}),
    .len   (vlen),
    .bad   (range_bad)
  );

  vidx_seq #(
    .NREG(NREG), .DW(DW), .AW(AW), .LW(LW)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .idx_base   (idx_base),
    .src_base   (src_base),
    .dst_base   (dst_base),
    .vlen       (vlen),
    .range_bad  (range_bad),
    .rf_rd_en   (rf_rd_en),
    .rf_rd_addr (rf_rd_addr),
    .rf_rd_data (rf_rd_data),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_addr (rf_wr_addr),
    .rf_wr_data (rf_wr_data),
    .busy       (busy),
    .done       (done),
    .trap       (trap),
    .trap_cause (trap_cause),
    .trap_elem  (trap_elem)
  );

  // R4: a command reaching past the file end faults at once, with no access
  assert_range_trap_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vlen != '0 && range_bad) |=>
      (trap && trap_cause == 2'd1 && !rf_rd_en && !busy));

  // R8: a zero-length command completes at once with no access
  assert_empty_done_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vlen == '0) |=> (done && !rf_rd_en && !busy));
endmodule

// File: tb/vidx_move_bench.sv
module vidx_move_bench;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int AW   = 5;
  localparam int LW   = 6;
  localparam int NCASE = 9;

  // entry layout: {idx_base[5], src_base[5], dst_base[5], vlen[6], indices 8x4}
  localparam logic [52:0] CASES [NCASE] = '{
    {5'd0,  5'd10, 5'd20, 6'd7, 32'h04443355},
    {5'd2,  5'd12, 5'd22, 6'd4, 32'h00000123},
    {5'd0,  5'd8,  5'd16, 6'd5, 32'h00043210},
    {5'd4,  5'd4,  5'd5,  6'd3, 32'h00000210},
    {5'd0,  5'd10, 5'd20, 6'd4, 32'h00002401},
    {5'd28, 5'd0,  5'd8,  6'd4, 32'h00000000},
    {5'd27, 5'd0,  5'd8,  6'd4, 32'h00002013},
    {5'd0,  5'd4,  5'd29, 6'd3, 32'h00000210},
    {5'd0,  5'd8,  5'd16, 6'd8, 32'h77777777}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] idx_base = '0, src_base = '0, dst_base = '0;
  logic [LW-1:0] vlen = '0;
  logic          rf_rd_en, rf_wr_en;
  logic [AW-1:0] rf_rd_addr, rf_wr_addr;
  logic [DW-1:0] rf_rd_data, rf_wr_data;
  logic          busy, done, trap;
  logic [1:0]    trap_cause;
  logic [LW-1:0] trap_elem;

  logic [DW-1:0] mem      [NREG];
  logic [DW-1:0] init_img [NREG];
  logic [DW-1:0] exp_mem  [NREG];
  logic          load_req = 1'b0;
  int            wr_count;
  int            n_checks = 0;
  int            n_errors = 0;
  bit            exp_trap;
  int            exp_cause, exp_elem;

  always #4 clk = ~clk;

  vidx_move #(.NREG(NREG), .DW(DW)) u_vidx_move (
    .clk(clk), .rst(rst), .start(start),
    .idx_base(idx_base), .src_base(src_base), .dst_base(dst_base), .vlen(vlen),
    .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .busy(busy), .done(done), .trap(trap),
    .trap_cause(trap_cause), .trap_elem(trap_elem)
  );

  always @(posedge clk) begin
    if (load_req) begin
      for (int k = 0; k < NREG; k++) mem[k] <= init_img[k];
      wr_count <= 0;
    end else if (rf_wr_en) begin
      mem[rf_wr_addr] <= rf_wr_data;
      wr_count <= wr_count + 1;
    end
    if (rf_rd_en) rf_rd_data <= mem[rf_rd_addr];
  end

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sequential reference of the requirements
  task automatic model(input int ra, input int rb, input int rd, input int vl);
    for (int k = 0; k < NREG; k++) exp_mem[k] = init_img[k];
    exp_trap = 0; exp_cause = 0; exp_elem = 0;
    if (vl == 0) return;
    if (ra + vl >= NREG || rb + vl >= NREG || rd + vl >= NREG) begin
      exp_trap = 1; exp_cause = 1; return;
    end
    for (int i = 0; i < vl; i++) begin
      longint idx = exp_mem[ra + i];
      if (idx >= vl) begin
        exp_trap = 1; exp_cause = 2; exp_elem = i; return;
      end
      exp_mem[rd + i] = exp_mem[rb + int'(idx)];
    end
  endtask

  task automatic prepare(input int ra, input int vl, input logic [31:0] idxs);
    for (int k = 0; k < NREG; k++) init_img[k] = DW'(32'h100 + k);
    for (int j = 0; j < vl && j < 8; j++)
      if (ra + j < NREG) init_img[ra + j] = DW'(idxs[4*j +: 4]);
    @(negedge clk) load_req = 1'b1;
    @(negedge clk) load_req = 1'b0;
  endtask

  task automatic issue(input int ra, input int rb, input int rd, input int vl);
    @(negedge clk);
    idx_base = AW'(ra); src_base = AW'(rb); dst_base = AW'(rd); vlen = LW'(vl);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic await_end(output bit got);
    got = 0;
    for (int t = 0; t < 1000 && !got; t++) begin
      if (done || trap) got = 1;
      else @(negedge clk);
    end
  endtask

  task automatic compare_result(input string tag, input bit got);
    int bad = 0, first = -1;
    check({tag, " finished"}, got, got, 1);
    check({tag, " trap flag"}, trap == exp_trap, trap, exp_trap);
    check({tag, " done flag"}, done == !exp_trap, done, !exp_trap);
    if (exp_trap) begin
      check({tag, " cause"}, trap_cause == 2'(exp_cause), trap_cause, exp_cause);
      if (exp_cause == 2) check({tag, " elem"}, trap_elem == LW'(exp_elem), trap_elem, exp_elem);
    end
    @(negedge clk);
    for (int k = 0; k < NREG; k++)
      if (mem[k] !== exp_mem[k]) begin bad++; if (first < 0) first = k; end
    if (first < 0) first = 0;
    check({tag, " register image"}, bad == 0, mem[first], exp_mem[first]);
  endtask

  function automatic string case_tag(input int c);
    case (c)
      0: return "R3";
      3: return "R6";
      4: return "R5";
      5, 7: return "R4";
      6, 8: return "R10";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1 reset outputs", {busy, done, trap, rf_rd_en, rf_wr_en} == 5'b0,
          {busy, done, trap, rf_rd_en, rf_wr_en}, 0);

    for (int c = 0; c < NCASE; c++) begin
      int ra = int'(CASES[c][52:48]);
      int rb = int'(CASES[c][47:43]);
      int rd = int'(CASES[c][42:38]);
      int vl = int'(CASES[c][37:32]);
      prepare(ra, vl, CASES[c][31:0]);
      model(ra, rb, rd, vl);
      issue(ra, rb, rd, vl);
      await_end(got);
      compare_result($sformatf("%s case%0d", case_tag(c), c), got);
      if (exp_cause == 1) check("R4 no writes", wr_count == 0, wr_count, 0);
    end

    // R7: done lasts one cycle
    prepare(0, 3, 32'h00000012);
    model(0, 8, 16, 3);
    issue(0, 8, 16, 3);
    await_end(got);
    check("R7 done seen", done, done, 1);
    @(negedge clk);
    check("R7 done single cycle", !done, done, 0);

    // R8: empty command
    prepare(0, 0, 32'h0);
    issue(3, 4, 5, 0);
    check("R8 done next cycle", done && !trap, done, 1);
    @(negedge clk);
    check("R8 no accesses", wr_count == 0 && !busy, wr_count, 0);

    // R9: start while busy is dropped
    prepare(0, 5, 32'h00001234);
    model(0, 8, 16, 5);
    issue(0, 8, 16, 5);
    repeat (3) @(negedge clk);
    idx_base = 5'd1; src_base = 5'd2; dst_base = 5'd3; vlen = 6'd2;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    await_end(got);
    compare_result("R9 midrun start", got);
    check("R9 write count", wr_count == 5, wr_count, 5);
    repeat (20) @(negedge clk);
    check("R9 nothing queued", !busy && wr_count == 5, wr_count, 5);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule